// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits between a host read interface and a flash array. It decides whether a read is asynchronous or a clocked burst, and in burst mode it produces the array address for every beat. In asynchronous mode the host address goes straight to the array, data-valid follows chip enable and output enable, and the clock and address-valid strobe do nothing.

A bit in the configuration register turns burst mode on. With burst mode on, the host presents one start address together with address-valid. On each clock edge after that, the sequencer steps through the burst. The burst order and length are fixed when the burst starts, and the first valid beat can be delayed by a programmable number of cycles. A reset command from the command decoder stops the current burst but keeps burst mode. Only the system reset puts the block back into asynchronous operation.

Top module: `burst_read_seq`

## Requirements
- R1: After `rst_ni` is asserted, the block is in asynchronous mode. This holds while reset is low and after it is released, until the configuration register enables burst mode again.
- R2: In asynchronous mode `array_addr_o` equals `addr_i` combinationally and `data_valid_o` equals `ce_i & oe_i`. `clk_i` and `adv_i` have no effect on either output.
- R3: A configuration write (`cfg_we_i`) with `cfg_sync_en_i=1` enters burst mode at the next clock edge. A write with `cfg_sync_en_i=0` leaves burst mode and ends any burst in progress.
- R4: A `cmd_reset_i` pulse in burst mode ends the current burst, so `data_valid_o` goes low after that edge. It does not leave burst mode: `addr_i` is still ignored, and the next load starts a new burst.
- R5: In burst mode a burst loads on a clock edge where `ce_i` and `adv_i` are both high. The first beat address is the `addr_i` sampled on that edge. At all other times `addr_i` is ignored.
- R6: The length code `cfg_len_i` is 0=4, 1=8, 2=16 or 3=continuous. A fixed-length burst gives exactly that many valid beats and then holds `data_valid_o` low until the next load. A continuous burst increments the full address and wraps at 2^ADDR_W.
- R7: In linear order (`cfg_order_i=0`) with a fixed length L, beat b has low log2(L) address bits equal to (start + b) mod L. The upper bits stay those of the start address.
- R8: In interleaved order (`cfg_order_i=1`) with a fixed length L, beat b has low log2(L) bits equal to start XOR b, and the upper bits are held. In a continuous burst, interleaved order behaves as linear.
- R9: With latency code N (`cfg_lat_i`), the first valid beat appears N clock edges after the load edge. The address does not advance before that beat.
- R10: Dropping `ce_i` forces `data_valid_o` low at once, without waiting for a clock edge. The next edge ends the burst, and raising `ce_i` again without a new load gives no valid beats.
- R11: While `oe_i` is low, `data_valid_o` stays low but the beats keep advancing on each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock |
| rst_ni | input | 1 | Active-low asynchronous system/power-on reset |
| cmd_reset_i | input | 1 | Reset command pulse from the command decoder |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_sync_en_i | input | 1 | Burst mode enable field |
| cfg_order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| cfg_len_i | input | 2 | Burst length code |
| cfg_lat_i | input | LAT_W | Initial latency in clock cycles |
| ce_i | input | 1 | Chip enable, active high |
| oe_i | input | 1 | Output enable, active high |
| adv_i | input | 1 | Address valid strobe, active high |
| addr_i | input | ADDR_W | Host address |
| array_addr_o | output | ADDR_W | Address to the array |
| data_valid_o | output | 1 | Current beat/read data is valid |

## Verification
The bench uses the default parameters, ADDR_W=16 and LAT_W=4. A 16-bit address lets a continuous burst started at 0xFFFE show the wrap to zero within a few beats. Start addresses sit in the middle of each wrap group, so the 4-, 8- and 16-beat groups show the wrap or the XOR pattern. Latency values of 0, 1 and 3 cover a first beat with no delay and with a delay, both within a short run.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {BL_4 = 2'd0, BL_8 = 2'd1, BL_16 = 2'd2, BL_CONT = 2'd3} burst_len_e;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_INTLV = 1'b1} burst_ord_e;

  function automatic logic [4:0] burst_beats(burst_len_e len);
    case (len)
      BL_4:    return 5'd4;
      BL_8:    return 5'd8;
      BL_16:   return 5'd16;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
  import burst_seq_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sync_en_i,
  input  logic             order_i,
  input  logic [1:0]       len_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             sync_en_o,
  output burst_ord_e       order_o,
  output burst_len_e       len_o,
  output logic [LAT_W-1:0] lat_o
);
  // only the system reset clears the mode; command resets never reach here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_en_o <= 1'b0;
      order_o   <= ORD_LINEAR;
      len_o     <= BL_4;
      lat_o     <= '0;
    end else if (we_i) begin
      sync_en_o <= sync_en_i;
      order_o   <= burst_ord_e'(order_i);
      len_o     <= burst_len_e'(len_i);
      lat_o     <= lat_i;
    end
  end
endmodule

// File: rtl/bseq_lat_ctr.sv
module bseq_lat_ctr #(
  parameter int LAT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             zero_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= lat_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] start_i,
  input  burst_ord_e        order_i,
  input  burst_len_e        len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] start_q, beat_q, mask, base, lin_addr, il_addr;
  burst_ord_e        ord_q;
  burst_len_e        len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_LINEAR;
      len_q   <= BL_4;
    end else if (load_i) begin
      start_q <= start_i;
      beat_q  <= '0;
      ord_q   <= order_i;
      len_q   <= len_i;
    end else if (step_i) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  // wrap mask: all ones for continuous bursts
  always_comb begin
    case (len_q)
      BL_4:    mask = ADDR_W'(4'd3);
      BL_8:    mask = ADDR_W'(4'd7);
      BL_16:   mask = ADDR_W'(4'd15);
      default: mask = '1;
    endcase
  end

  assign base     = start_q & ~mask;
  assign lin_addr = base | ((start_q + beat_q) & mask);
  assign il_addr  = base | ((start_q ^ beat_q) & mask);

  assign addr_o = (ord_q == ORD_INTLV && len_q != BL_CONT) ? il_addr : lin_addr;
  assign last_o = (len_q != BL_CONT) && (beat_q == mask);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LAT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_reset_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sync_en_i,
  input  logic              cfg_order_i,
  input  logic [1:0]        cfg_len_i,
  input  logic [LAT_W-1:0]  cfg_lat_i,
  input  logic              ce_i,
  input  logic              oe_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] array_addr_o,
  output logic              data_valid_o
);
  logic             burst_en;
  burst_ord_e       cfg_order;
  burst_len_e       cfg_len;
  logic [LAT_W-1:0] cfg_lat;
  logic             lat_zero, last_beat, active_q;
  logic             load, kill, step;
  logic [ADDR_W-1:0] gen_addr;

  bseq_cfg_reg #(.LAT_W(LAT_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sync_en_i (cfg_sync_en_i),
    .order_i   (cfg_order_i),
    .len_i     (cfg_len_i),
    .lat_i     (cfg_lat_i),
    .sync_en_o (burst_en),
    .order_o   (cfg_order),
    .len_o     (cfg_len),
    .lat_o     (cfg_lat)
  );

  assign kill = !ce_i || cmd_reset_i || !burst_en || (cfg_we_i && !cfg_sync_en_i);
  assign load = burst_en && ce_i && adv_i && !kill;
  assign step = active_q && lat_zero && !load && !kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                active_q <= 1'b0;
    else if (kill)              active_q <= 1'b0;
    else if (load)              active_q <= 1'b1;
    else if (step && last_beat) active_q <= 1'b0;
  end

  bseq_lat_ctr #(.LAT_W(LAT_W)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .lat_i  (cfg_lat),
    .zero_o (lat_zero)
  );

  bseq_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .step_i  (step && !last_beat),
    .start_i (addr_i),
    .order_i (cfg_order),
    .len_i   (cfg_len),
    .addr_o  (gen_addr),
    .last_o  (last_beat)
  );

  // ce/oe gate the output without waiting for a clock
  assign array_addr_o = burst_en ? gen_addr : addr_i;
  assign data_valid_o = burst_en ? (active_q && lat_zero && ce_i && oe_i) : (ce_i && oe_i);
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LAT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              burst_en_i,
  input logic              cmd_reset_i,
  input logic              cfg_we_i,
  input logic              cfg_sync_en_i,
  input logic [1:0]        cfg_len_i,
  input logic [LAT_W-1:0]  cfg_lat_i,
  input logic              ce_i,
  input logic              oe_i,
  input logic              adv_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] array_addr_i,
  input logic              data_valid_i
);
  logic       ld;
  logic [5:0] vcnt_q;
  burst_len_e len_q;

  assign ld = burst_en_i && ce_i && adv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q <= '0;
      len_q  <= BL_CONT;
    end else if (ld) begin
      vcnt_q <= '0;
      len_q  <= burst_len_e'(cfg_len_i);
    end else if (burst_en_i && data_valid_i && vcnt_q != 6'h3f) begin
      vcnt_q <= vcnt_q + 1'b1;
    end
  end

  p_async_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_en_i |-> (data_valid_i == (ce_i && oe_i)) && (array_addr_i == addr_i));

  p_mode_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_en_i && cmd_reset_i && !cfg_we_i |=> burst_en_i);

  p_first_beat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_en_i && ce_i && adv_i && !cmd_reset_i && !cfg_we_i && cfg_lat_i == '0
    |=> !data_valid_i || array_addr_i == $past(addr_i));

  p_beat_limit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_en_i && data_valid_i && !ld && len_q != BL_CONT
    |-> vcnt_q < 6'(burst_beats(len_q)));

  p_valid_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_i |-> ce_i && oe_i);
endmodule

bind burst_read_seq bseq_checker #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_en_i    (burst_en),
  .cmd_reset_i   (cmd_reset_i),
  .cfg_we_i      (cfg_we_i),
  .cfg_sync_en_i (cfg_sync_en_i),
  .cfg_len_i     (cfg_len_i),
  .cfg_lat_i     (cfg_lat_i),
  .ce_i          (ce_i),
  .oe_i          (oe_i),
  .adv_i         (adv_i),
  .addr_i        (addr_i),
  .array_addr_i  (array_addr_o),
  .data_valid_i  (data_valid_o)
);

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;
  localparam int ADDR_W = 16;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_reset_i = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic              cfg_sync_en_i = 1'b0;
  logic              cfg_order_i = 1'b0;
  logic [1:0]        cfg_len_i = 2'd0;
  logic [LAT_W-1:0]  cfg_lat_i = '0;
  logic              ce_i = 1'b0;
  logic              oe_i = 1'b0;
  logic              adv_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] array_addr_o;
  logic              data_valid_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_read_seq #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_burst_read_seq (
    .clk_i (clk), .rst_ni (rst_ni), .cmd_reset_i (cmd_reset_i),
    .cfg_we_i (cfg_we_i), .cfg_sync_en_i (cfg_sync_en_i), .cfg_order_i (cfg_order_i),
    .cfg_len_i (cfg_len_i), .cfg_lat_i (cfg_lat_i), .ce_i (ce_i), .oe_i (oe_i),
    .adv_i (adv_i), .addr_i (addr_i), .array_addr_o (array_addr_o), .data_valid_o (data_valid_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr_cfg(bit en, bit ord, int len, int lat);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sync_en_i = en; cfg_order_i = ord;
    cfg_len_i = 2'(len); cfg_lat_i = LAT_W'(lat);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  function automatic int exp_addr(int start, int b, bit ord, int len);
    int l, grp, off;
    if (len == 3) return (start + b) & 16'hFFFF;
    l   = 4 << len;
    off = start % l;
    grp = start - off;
    if (ord) return grp + (off ^ b);
    return grp + ((off + b) % l);
  endfunction

  // load a burst, check latency gap, n beats, and the end for fixed lengths
  task automatic run_burst(int start, bit ord, int len, int lat, int n, bit chk_end, string req);
    @(negedge clk);
    ce_i = 1'b1; oe_i = 1'b1; adv_i = 1'b1; addr_i = ADDR_W'(start);
    @(negedge clk);
    adv_i = 1'b0; addr_i = 16'hDEAD;
    #1;
    for (int i = 0; i < lat; i++) begin
      chk({req, " R9 latency gap"}, int'(data_valid_o), 0);
      step();
    end
    for (int b = 0; b < n; b++) begin
      chk({req, " valid"}, int'(data_valid_o), 1);
      chk({req, " addr"}, int'(array_addr_o), exp_addr(start, b, ord, len));
      step();
    end
    if (chk_end) chk({req, " R6 end of burst"}, int'(data_valid_o), 0);
  endtask

  task automatic t_reset_r1();
    #1;
    addr_i = 16'h4321;
    #1;
    chk("R1 reset addr passthrough", int'(array_addr_o), 16'h4321);
    chk("R1 reset valid low", int'(data_valid_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_async_r2();
    @(negedge clk);
    ce_i = 1'b1; oe_i = 1'b1; adv_i = 1'b1; addr_i = 16'h0100;
    step();
    adv_i = 1'b0; addr_i = 16'h0badd;
    #1;
    chk("R2 addr follows without clock", int'(array_addr_o), 16'h0badd);
    chk("R2 valid=ce&oe", int'(data_valid_o), 1);
    oe_i = 1'b0;
    #1;
    chk("R2 valid drops with oe", int'(data_valid_o), 0);
    oe_i = 1'b1;
  endtask

  task automatic t_linear4_r7();
    wr_cfg(1'b1, 1'b0, 0, 0);
    run_burst(16'h0106, 1'b0, 0, 0, 4, 1'b1, "R3 R5 R7 len4 linear");
  endtask

  task automatic t_intlv8_r8();
    wr_cfg(1'b1, 1'b1, 1, 0);
    run_burst(16'h0023, 1'b1, 1, 0, 8, 1'b1, "R8 len8 interleaved");
  endtask

  task automatic t_lin16_lat_r9();
    wr_cfg(1'b1, 1'b0, 2, 3);
    run_burst(16'h00FE, 1'b0, 2, 3, 16, 1'b1, "R9 R7 len16 lat3");
  endtask

  task automatic t_cont_r6();
    wr_cfg(1'b1, 1'b1, 3, 0);
    run_burst(16'hFFFE, 1'b0, 3, 0, 20, 1'b0, "R6 R8 continuous wrap");
  endtask

  task automatic t_ce_release_r10();
    wr_cfg(1'b1, 1'b0, 2, 0);
    run_burst(16'h0300, 1'b0, 2, 0, 2, 1'b0, "R10 pre");
    ce_i = 1'b0;
    #1;
    chk("R10 valid drops at once", int'(data_valid_o), 0);
    @(negedge clk);
    ce_i = 1'b1;
    #1;
    chk("R10 no resume after ce", int'(data_valid_o), 0);
    step();
    chk("R10 still ended", int'(data_valid_o), 0);
  endtask

  task automatic t_oe_gate_r11();
    wr_cfg(1'b1, 1'b0, 1, 0);
    @(negedge clk);
    ce_i = 1'b1; oe_i = 1'b0; adv_i = 1'b1; addr_i = 16'h0041;
    @(negedge clk);
    adv_i = 1'b0;
    #1;
    chk("R11 oe low beat0", int'(data_valid_o), 0);
    step();
    chk("R11 oe low beat1", int'(data_valid_o), 0);
    oe_i = 1'b1;
    #1;
    chk("R11 valid beat1", int'(data_valid_o), 1);
    chk("R11 advanced addr", int'(array_addr_o), 16'h0042);
    step();
    chk("R11 next addr", int'(array_addr_o), 16'h0043);
  endtask

  task automatic t_cmd_reset_r4();
    wr_cfg(1'b1, 1'b0, 3, 1);
    run_burst(16'h0500, 1'b0, 3, 1, 3, 1'b0, "R4 pre");
    @(negedge clk);
    cmd_reset_i = 1'b1;
    @(negedge clk);
    cmd_reset_i = 1'b0;
    addr_i = 16'h7777;
    #1;
    chk("R4 burst ended", int'(data_valid_o), 0);
    chk("R4 addr_i ignored", int'(array_addr_o == addr_i), 0);
    run_burst(16'h0A10, 1'b0, 3, 1, 4, 1'b0, "R4 still burst mode");
  endtask

  task automatic t_exit_r3();
    wr_cfg(1'b0, 1'b0, 0, 0);
    addr_i = 16'h1357;
    #1;
    chk("R3 exit passthrough", int'(array_addr_o), 16'h1357);
    chk("R3 exit valid", int'(data_valid_o), 1);
    @(negedge clk);
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0; addr_i = 16'h2468;
    #1;
    chk("R3 adv ignored after exit", int'(array_addr_o), 16'h2468);
  endtask

  task automatic t_sys_reset_r1();
    wr_cfg(1'b1, 1'b0, 0, 0);
    run_burst(16'h0010, 1'b0, 0, 0, 1, 1'b0, "R1 pre");
    rst_ni = 1'b0;
    addr_i = 16'hABCD;
    #1;
    chk("R1 system reset leaves burst", int'(array_addr_o), 16'hABCD);
    @(negedge clk);
    rst_ni = 1'b1;
    adv_i = 1'b1; addr_i = 16'h0010;
    @(negedge clk);
    adv_i = 1'b0; addr_i = 16'h0020;
    #1;
    chk("R1 async after reset", int'(array_addr_o), 16'h0020);
    chk("R1 async valid", int'(data_valid_o), 1);
  endtask

  initial begin
    t_reset_r1();
    t_async_r2();
    t_linear4_r7();
    t_intlv8_r8();
    t_lin16_lat_r9();
    t_cont_r6();
    t_ce_release_r10();
    t_oe_gate_r11();
    t_cmd_reset_r4();
    t_exit_r3();
    t_sys_reset_r1();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule